// File: doc/BRIEF.md
# Instruction Fetch Front End with Decode-Stage Branch Redirect

This block is the front of a small in-order pipeline. It holds the program counter, reads instruction words from a small internal instruction ROM, and loads each word into a fetch-to-decode pipeline register together with the address it was read from. Decode looks at that register. When decode finds an unconditional PC-relative branch, it adds the branch's signed offset to the branch's own saved address. The program counter loads that sum at the next edge. A branch therefore redirects fetch two clock periods after it was fetched.

One instruction is already being fetched while the branch sits in decode. Its treatment is chosen at reset. In delay-slot mode that instruction is kept and issued. In stall mode fetch is held off for that cycle and an invalid bubble goes down instead. A branch that lands in a delay slot is issued as an ordinary instruction and does not redirect. The decode-stage contents are driven on the output port every cycle for a downstream execute stage.

Top module: `fetch_branch_frontend`

## Requirements
- R1: While reset is high, the program counter is loaded with 0 and the output valid flag is cleared at each clock edge.
- R2: When decode holds no redirecting branch, the fetch address advances by 4 bytes at each edge. The word issued is the ROM word at its address.
- R3: The address issued with each valid instruction equals the fetch address from which that word was read.
- R4: An instruction word with bits [15:12] equal to 4'hC is an unconditional branch. Bits [11:0] are a two's-complement byte offset, and the target is the branch's own address plus that offset, modulo the address space.
- R5: When a branch in decode redirects, the fetch address equals its target after the next clock edge, two edges after the branch was fetched.
- R6: In delay-slot mode, the instruction fetched while a branch sits in decode is issued as valid in the next cycle, and the target is issued after it.
- R7: In stall mode, the cycle after a redirecting branch carries an invalid bubble, and the next valid instruction is the one at the target.
- R8: A branch issued from a delay slot does not redirect fetch, and the fetch address continues sequentially.
- R9: The mode input (1 = delay slot, 0 = stall) is sampled only while reset is high. Changes after reset have no effect on issue.
- R10: A branch at address 12 with offset +44 makes fetch continue at address 56.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| delay_mode | input | 1 | 1 = delay slot, 0 = stall; captured during reset |
| fetch_pc | output | ADDR_W | Current fetch address |
| out_valid | output | 1 | Decode stage holds a real instruction |
| out_pc | output | ADDR_W | Address of the decoded instruction |
| out_instr | output | 16 | Decoded instruction word |
| out_redirect | output | 1 | Decode holds a branch that redirects fetch |

## Verification
The built-in program runs in both modes. It contains a forward branch at address 12 and a forward branch whose delay slot holds a backward branch. A backward branch then closes a loop to address 0. Delay-slot runs and stall runs of the same code are told apart by whether the slot instruction or a bubble follows each branch. The slot-held backward branch tells a decoder that ignores slot status apart from one that honours it. During one run the mode input is toggled after reset, which exposes a design that samples the mode input live.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int INSTR_W = 16;
  localparam logic [3:0] OPC_JUMP = 4'hC;
  localparam logic [3:0] OPC_PLAIN = 4'h1;

  function automatic logic is_jump(input logic [INSTR_W-1:0] w);
    return w[15:12] == OPC_JUMP;
  endfunction

  // target = own address + sign-extended 12-bit byte offset
  function automatic logic [31:0] jump_target(input logic [31:0] pc,
                                               input logic [INSTR_W-1:0] w);
    return pc + {{20{w[11]}}, w[11:0]};
  endfunction

  // Built-in program, indexed by word
  function automatic logic [INSTR_W-1:0] rom_word(input int idx);
    case (idx)
      3:       return {OPC_JUMP, 12'd44};     // at 12 -> 56
      14:      return {OPC_JUMP, 12'd16};     // at 56 -> 72
      15:      return {OPC_JUMP, 12'hFD8};    // at 60, -40, slot branch
      18:      return {OPC_JUMP, 12'hFB8};    // at 72 -> 0
      default: return {OPC_PLAIN, 4'h0, 8'(idx)};
    endcase
  endfunction
endpackage

// File: rtl/fe_pc_reg.sv
module fe_pc_reg #(
  parameter int ADDR_W = 7,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc_q
);
  logic [ADDR_W-1:0] seq_pc;
  assign seq_pc = pc_q + ADDR_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= '0;
    else if (redirect) pc_q <= target;
    else               pc_q <= seq_pc;
  end

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> (pc_q == '0));
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!redirect) |=> (pc_q == $past(pc_q) + ADDR_W'(STEP)));
  p_redirect_r5: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (pc_q == $past(target)));
endmodule

// File: rtl/fe_irom.sv
module fe_irom #(
  parameter int ADDR_W = 7,
  parameter int DEPTH  = 32
) (
  input  logic [ADDR_W-1:0]          addr,
  output logic [fe_pkg::INSTR_W-1:0] word
);
  localparam int IDX_W = $clog2(DEPTH);
  logic [fe_pkg::INSTR_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign mem[i] = fe_pkg::rom_word(i);
  end

  assign idx  = IDX_W'(addr >> 2);
  assign word = mem[idx];
endmodule

// File: rtl/fe_decode.sv
module fe_decode #(
  parameter int ADDR_W = 7
) (
  input  logic                       valid,
  input  logic                       in_slot,
  input  logic [ADDR_W-1:0]          pc,
  input  logic [fe_pkg::INSTR_W-1:0] instr,
  output logic                       redirect,
  output logic [ADDR_W-1:0]          target
);
  assign redirect = valid && !in_slot && fe_pkg::is_jump(instr);
  assign target   = ADDR_W'(fe_pkg::jump_target(32'(pc), instr));

  always_comb begin
    p_slot_quiet_r8: assert (!(valid && in_slot) || !redirect);
  end
endmodule

// File: rtl/fe_ifid.sv
module fe_ifid #(
  parameter int ADDR_W = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       slot_mode,
  input  logic                       redirect,
  input  logic [ADDR_W-1:0]          fetch_pc,
  input  logic [fe_pkg::INSTR_W-1:0] fetch_word,
  output logic                       valid_q,
  output logic                       slot_q,
  output logic [ADDR_W-1:0]          pc_q,
  output logic [fe_pkg::INSTR_W-1:0] instr_q
);
  logic bubble;
  assign bubble = redirect && !slot_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      slot_q  <= 1'b0;
      pc_q    <= '0;
      instr_q <= '0;
    end else if (bubble) begin
      valid_q <= 1'b0;
      slot_q  <= 1'b0;
    end else begin
      valid_q <= 1'b1;
      slot_q  <= redirect;
      pc_q    <= fetch_pc;
      instr_q <= fetch_word;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !valid_q);
  p_pc_copy_r3: assert property (@(posedge clk) disable iff (rst)
    (!bubble) |=> (valid_q && pc_q == $past(fetch_pc)));
  p_bubble_r7: assert property (@(posedge clk) disable iff (rst)
    bubble |=> !valid_q);
  p_slot_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (redirect && slot_mode) |=> (valid_q && slot_q));
endmodule

// File: rtl/fetch_branch_frontend.sv
module fetch_branch_frontend #(
  parameter int ADDR_W    = 7,
  parameter int ROM_DEPTH = 32,
  parameter int STEP      = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       delay_mode,
  output logic [ADDR_W-1:0]          fetch_pc,
  output logic                       out_valid,
  output logic [ADDR_W-1:0]          out_pc,
  output logic [fe_pkg::INSTR_W-1:0] out_instr,
  output logic                       out_redirect
);
  logic                       mode_q;
  logic                       redirect;
  logic [ADDR_W-1:0]          target;
  logic [fe_pkg::INSTR_W-1:0] fetch_word;
  logic                       id_slot;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= delay_mode;
  end

  fe_pc_reg #(.ADDR_W(ADDR_W), .STEP(STEP)) u_pc (
    .clk(clk), .rst(rst), .redirect(redirect), .target(target), .pc_q(fetch_pc));

  fe_irom #(.ADDR_W(ADDR_W), .DEPTH(ROM_DEPTH)) u_rom (
    .addr(fetch_pc), .word(fetch_word));

  fe_ifid #(.ADDR_W(ADDR_W)) u_ifid (
    .clk(clk), .rst(rst), .slot_mode(mode_q), .redirect(redirect),
    .fetch_pc(fetch_pc), .fetch_word(fetch_word),
    .valid_q(out_valid), .slot_q(id_slot), .pc_q(out_pc), .instr_q(out_instr));

  fe_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid(out_valid), .in_slot(id_slot), .pc(out_pc), .instr(out_instr),
    .redirect(redirect), .target(target));

  assign out_redirect = redirect;

  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));
endmodule

// File: tb/fetch_branch_frontend_tb.sv
module fetch_branch_frontend_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic delay_mode = 1'b1;
  logic [6:0]  fetch_pc;
  logic        out_valid;
  logic [6:0]  out_pc;
  logic [15:0] out_instr;
  logic        out_redirect;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state: expected register contents after last edge
  int m_pc, m_ipc, m_ins;
  bit m_v, m_slot, m_mode, m_was_red, m_ex12, m_toggled;

  always #2.5 clk = ~clk;

  fetch_branch_frontend u_dut (
    .clk(clk), .rst(rst), .delay_mode(delay_mode), .fetch_pc(fetch_pc),
    .out_valid(out_valid), .out_pc(out_pc), .out_instr(out_instr),
    .out_redirect(out_redirect));

  function automatic int brom(int a);
    case (a)
      12: return 'hC02C;
      56: return 'hC010;
      60: return 'hCFD8;
      72: return 'hCFB8;
      default: return 'h1000 + a / 4;
    endcase
  endfunction

  function automatic int dest(int a, int w);
    int off = w % 4096;
    if (off >= 2048) off -= 4096;
    return ((a + off) % 128 + 128) % 128;
  endfunction

  function automatic bit m_red();
    return m_v && !m_slot && (m_ins / 4096 == 12);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    string vt = m_toggled ? "R9" : (m_mode ? "R6" : "R7");
    chk(m_was_red ? "R5 fetch_pc" : "R2 fetch_pc", int'(fetch_pc), m_pc);
    if (m_ex12) chk("R10 fetch_pc", int'(fetch_pc), 56);
    chk({vt, " out_valid"}, int'(out_valid), int'(m_v));
    if (m_v) begin
      chk("R3 out_pc", int'(out_pc), m_ipc);
      chk("R2 out_instr", int'(out_instr), m_ins);
      chk(m_slot ? "R8 out_redirect" : "R4 out_redirect",
          int'(out_redirect), int'(m_red()));
    end
  endtask

  task automatic step_model();
    bit red;
    int tgt;
    if (rst) begin
      m_pc = 0; m_v = 0; m_slot = 0; m_mode = delay_mode;
      m_was_red = 0; m_ex12 = 0;
      return;
    end
    red = m_red();
    tgt = dest(m_ipc, m_ins);
    m_was_red = red;
    m_ex12 = red && m_ipc == 12;
    if (red && !m_mode) begin
      m_v = 0; m_slot = 0; m_pc = tgt;
    end else begin
      m_v = 1; m_ins = brom(m_pc); m_ipc = m_pc; m_slot = red;
      m_pc = red ? tgt : (m_pc + 4) % 128;
    end
  endtask

  task automatic run(bit mode, int cycles, int toggle_at);
    @(negedge clk);
    rst = 1; delay_mode = mode; m_toggled = 0;
    step_model();
    @(negedge clk); step_model();
    @(negedge clk);
    chk("R1 fetch_pc after reset", int'(fetch_pc), 0);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    rst = 0;
    step_model();
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare();
      if (c == toggle_at) begin
        delay_mode = ~mode; m_toggled = 1;
      end
      step_model();
    end
  endtask

  initial begin
    run(1'b1, 70, 30);
    run(1'b0, 70, 35);
    run(1'b1, 40, 1000);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule